// File: doc/BRIEF.md
# RMII Receive Deserializer

This block sits between an RMII PHY and a MAC receive engine. It runs on the 50 MHz reference clock, where every cycle with carrier can hold a two-bit symbol. It ignores the zero symbols that the PHY puts out while its decoder settles. It waits for a run of `01` preamble symbols that ends in the `11` symbol completing the 0xD5 start delimiter. After that it packs each group of four symbols into a byte, lowest bits first. Each byte is delivered as a one-cycle beat that carries a first-byte marker and an error tag.

When carrier drops, the block emits a single end-of-frame beat. That beat reports whether a symbol error was seen during the frame and whether bytes were left incomplete. A partial trailing byte is dropped. In 10 Mbps mode a pacing counter takes one symbol on the first carrier cycle and on every tenth cycle after it. A registered collision output follows the local transmit enable combined with receive carrier.

Top module: `rmii_rx_deser`

## Requirements
- R1: After reset, `byte_valid`, `byte_first`, `byte_err`, `frame_end`, `frame_err`, `frame_align_err` and `col` are all 0.
- R2: Symbols of `00` received with `crs_dv` high before any `01` preamble symbol produce no byte and no end beat.
- R3: Alignment is reached only when a `11` symbol follows one or more `01` symbols. The next four symbols form a byte with the first symbol in bits [1:0] and the fourth in bits [7:6].
- R4: `byte_valid` is high for exactly one cycle, in the cycle after the clock edge that samples the fourth symbol of a byte. `byte_first` is 1 only on the first byte after alignment.
- R5: While `crs_dv` is low, `rxd` and `rx_er` have no effect: no byte, no end beat, and no error tag on the next frame.
- R6: `rx_er` sampled high with `crs_dv` high sets `byte_err` on that byte and on every later byte of the frame, and sets `frame_err` on the end beat.
- R7: `frame_end` pulses for one cycle after the first edge that samples `crs_dv` low, and only if alignment had been reached.
- R8: `frame_align_err` is 1 on the end beat when the symbols after alignment do not fill a whole number of bytes. The partial byte is never delivered.
- R9: With `speed_10` high, a symbol is taken on the first cycle of carrier and then every 10th cycle. Values in the other nine cycles are ignored.
- R10: `col` equals `tx_en AND crs_dv` as sampled at the previous clock edge.
- R11: Before alignment, a `10` or `00` symbol after preamble, or a `11` with no preamble before it, returns the block to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_10 | input | 1 | 1 selects 10 Mbps pacing, 0 selects 100 Mbps |
| crs_dv | input | 1 | Carrier/data valid from the PHY |
| rxd | input | 2 | Received symbol |
| rx_er | input | 1 | Symbol error from the PHY |
| tx_en | input | 1 | Local transmit enable |
| byte_valid | output | 1 | Byte beat strobe |
| byte_data | output | 8 | Assembled byte |
| byte_first | output | 1 | First byte of the frame |
| byte_err | output | 1 | Error seen in the frame up to this byte |
| frame_end | output | 1 | End-of-frame beat |
| frame_err | output | 1 | Frame carried a symbol error |
| frame_align_err | output | 1 | Frame ended on a partial byte |
| col | output | 1 | Registered collision indication |

## Verification
Every result is due one edge after the input that causes it. A byte appears after the edge that samples its fourth symbol, the end beat after the first low-carrier edge, and `col` after the edge that samples `tx_en` and `crs_dv`. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each step shows exactly the result of the edge before it. Scenario tasks count bytes and end beats at the step where they are due, so a beat that arrives one cycle early or late does not match.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
    typedef enum logic [1:0] {
        SYNC_HUNT = 2'd0,
        SYNC_PRE  = 2'd1,
        SYNC_DATA = 2'd2
    } sync_st_e;

    localparam logic [1:0] SYM_PREAMBLE = 2'b01;
    localparam logic [1:0] SYM_SFD_TAIL = 2'b11;
endpackage

// File: rtl/rmii_rx_pacer.sv
module rmii_rx_pacer #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_10,
    input  logic crs_dv,
    output logic take
);
    localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] WRAP = CW'(SLOW_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pace_t;

    pace_t pace_d, pace_q;

    always_comb begin
        pace_d = pace_q;
        if (!crs_dv || !speed_10) begin
            pace_d.cnt = '0;
        end else if (pace_q.cnt == WRAP) begin
            pace_d.cnt = '0;
        end else begin
            pace_d.cnt = pace_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pace_q <= '0;
        else        pace_q <= pace_d;
    end

    assign take = speed_10 ? (pace_q.cnt == '0) : 1'b1;

    // R9
    slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_10 && crs_dv && take) |=> (!take || !speed_10));
endmodule

// File: rtl/rmii_rx_align.sv
module rmii_rx_align
    import rmii_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crs_dv,
    input  logic              take,
    input  logic [1:0]        rxd,
    input  logic              rx_er,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_first,
    output logic              byte_err,
    output logic              frame_end,
    output logic              frame_err,
    output logic              frame_align_err
);
    localparam int SYMS  = BYTE_W / 2;
    localparam int CNT_W = (SYMS > 1) ? $clog2(SYMS) : 1;
    localparam logic [CNT_W-1:0] LAST_SYM = CNT_W'(SYMS - 1);

    typedef struct packed {
        sync_st_e          st;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              first;
        logic              err;
        logic              b_valid;
        logic [BYTE_W-1:0] b_data;
        logic              b_first;
        logic              b_err;
        logic              f_end;
        logic              f_err;
        logic              f_align;
    } asm_t;

    asm_t asm_d, asm_q;
    logic err_now;
    logic [BYTE_W-1:0] packed_byte;

    always_comb begin
        asm_d         = asm_q;
        asm_d.b_valid = 1'b0;
        asm_d.b_first = 1'b0;
        asm_d.b_err   = 1'b0;
        asm_d.f_end   = 1'b0;
        asm_d.f_err   = 1'b0;
        asm_d.f_align = 1'b0;
        err_now       = asm_q.err | (crs_dv & rx_er);
        packed_byte   = {rxd, asm_q.sh[BYTE_W-1:2]};

        if (!crs_dv) begin
            if (asm_q.st == SYNC_DATA) begin
                asm_d.f_end   = 1'b1;
                asm_d.f_err   = asm_q.err;
                asm_d.f_align = (asm_q.cnt != '0);
            end
            asm_d.st    = SYNC_HUNT;
            asm_d.sh    = '0;
            asm_d.cnt   = '0;
            asm_d.first = 1'b1;
            asm_d.err   = 1'b0;
        end else begin
            asm_d.err = err_now;
            if (take) begin
                unique case (asm_q.st)
                    SYNC_HUNT: begin
                        if (rxd == SYM_PREAMBLE) asm_d.st = SYNC_PRE;
                    end
                    SYNC_PRE: begin
                        if (rxd == SYM_SFD_TAIL) begin
                            asm_d.st    = SYNC_DATA;
                            asm_d.cnt   = '0;
                            asm_d.first = 1'b1;
                        end else if (rxd != SYM_PREAMBLE) begin
                            asm_d.st = SYNC_HUNT;
                        end
                    end
                    SYNC_DATA: begin
                        asm_d.sh = packed_byte;
                        if (asm_q.cnt == LAST_SYM) begin
                            asm_d.b_valid = 1'b1;
                            asm_d.b_data  = packed_byte;
                            asm_d.b_first = asm_q.first;
                            asm_d.b_err   = err_now;
                            asm_d.first   = 1'b0;
                            asm_d.cnt     = '0;
                        end else begin
                            asm_d.cnt = asm_q.cnt + 1'b1;
                        end
                    end
                    default: asm_d.st = SYNC_HUNT;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q       <= '0;
            asm_q.st    <= SYNC_HUNT;
            asm_q.first <= 1'b1;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign byte_valid      = asm_q.b_valid;
    assign byte_data       = asm_q.b_data;
    assign byte_first      = asm_q.b_first;
    assign byte_err        = asm_q.b_err;
    assign frame_end       = asm_q.f_end;
    assign frame_err       = asm_q.f_err;
    assign frame_align_err = asm_q.f_align;

    // R4
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_first |-> byte_valid);
    // R7
    beat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && frame_end));
    // R8
    align_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_align_err |-> frame_end);
    // R5
    carrier_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(crs_dv));
    // R7
    end_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !$past(crs_dv));
endmodule

// File: rtl/rmii_col_gen.sv
module rmii_col_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic crs_dv,
    output logic col
);
    typedef struct packed {
        logic col;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d     = col_q;
        col_d.col = tx_en & crs_dv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assign col = col_q.col;

    // R10
    col_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(crs_dv) |-> !col);
    // R10
    col_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_en) |-> !col);
endmodule

// File: rtl/rmii_rx_deser.sv
module rmii_rx_deser #(
    parameter int BYTE_W   = 8,
    parameter int SLOW_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_10,
    input  logic              crs_dv,
    input  logic [1:0]        rxd,
    input  logic              rx_er,
    input  logic              tx_en,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_first,
    output logic              byte_err,
    output logic              frame_end,
    output logic              frame_err,
    output logic              frame_align_err,
    output logic              col
);
    logic take;

    rmii_rx_pacer #(.SLOW_DIV(SLOW_DIV)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed_10 (speed_10),
        .crs_dv   (crs_dv),
        .take     (take)
    );

    rmii_rx_align #(.BYTE_W(BYTE_W)) u_align (
        .clk             (clk),
        .rst_n           (rst_n),
        .crs_dv          (crs_dv),
        .take            (take),
        .rxd             (rxd),
        .rx_er           (rx_er),
        .byte_valid      (byte_valid),
        .byte_data       (byte_data),
        .byte_first      (byte_first),
        .byte_err        (byte_err),
        .frame_end       (frame_end),
        .frame_err       (frame_err),
        .frame_align_err (frame_align_err)
    );

    rmii_col_gen u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_en  (tx_en),
        .crs_dv (crs_dv),
        .col    (col)
    );
endmodule

// File: tb/tb_rmii_rx_deser.sv
`timescale 1ns/1ps
module tb_rmii_rx_deser;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic speed_10 = 1'b0;
    logic crs_dv = 1'b0;
    logic [1:0] rxd = 2'b00;
    logic rx_er = 1'b0;
    logic tx_en = 1'b0;
    logic byte_valid, byte_first, byte_err;
    logic frame_end, frame_err, frame_align_err, col;
    logic [7:0] byte_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int nbytes = 0;
    int nend = 0;
    logic [7:0] got_data [16];
    logic       got_first [16];
    logic       got_err [16];
    logic       end_err, end_align;

    always #10 clk = ~clk;

    rmii_rx_deser dut (
        .clk(clk), .rst_n(rst_n), .speed_10(speed_10), .crs_dv(crs_dv),
        .rxd(rxd), .rx_er(rx_er), .tx_en(tx_en), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_first(byte_first), .byte_err(byte_err),
        .frame_end(frame_end), .frame_err(frame_err),
        .frame_align_err(frame_align_err), .col(col)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear();
        nbytes = 0;
        nend = 0;
        end_err = 1'b0;
        end_align = 1'b0;
    endtask

    task automatic step(input logic c, input logic [1:0] d, input logic e);
        crs_dv = c; rxd = d; rx_er = e;
        @(posedge clk);
        @(negedge clk);
        if (byte_valid && nbytes < 16) begin
            got_data[nbytes]  = byte_data;
            got_first[nbytes] = byte_first;
            got_err[nbytes]   = byte_err;
            nbytes++;
        end
        if (frame_end) begin
            nend++;
            end_err   = frame_err;
            end_align = frame_align_err;
        end
    endtask

    task automatic sym(input logic [1:0] d, input logic e);
        step(1'b1, d, e);
        if (speed_10) repeat (9) step(1'b1, ~d, 1'b0);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic e);
        for (int i = 0; i < 4; i++) sym(b[2*i +: 2], e && (i == 0));
    endtask

    task automatic lead_in(input int zeros, input int pre);
        for (int i = 0; i < zeros; i++) sym(2'b00, 1'b0);
        for (int i = 0; i < pre; i++) send_byte(8'h55, 1'b0);
        send_byte(8'hD5, 1'b0);
    endtask

    task automatic drop();
        step(1'b0, 2'b00, 1'b0);
    endtask

    task automatic t_reset();
        chk(!byte_valid && !byte_first && !byte_err, "R1 byte outputs", byte_valid, 0);
        chk(!frame_end && !frame_err && !frame_align_err, "R1 end outputs", frame_end, 0);
        chk(!col, "R1 col", col, 0);
    endtask

    task automatic t_basic();
        clear();
        lead_in(3, 3);
        chk(nbytes == 0, "R2 R3 no bytes from zeros/preamble", nbytes, 0);
        send_byte(8'hA7, 1'b0);
        chk(nbytes == 1, "R4 byte due after fourth symbol", nbytes, 1);
        chk(got_data[0] == 8'hA7, "R3 symbol order", got_data[0], 8'hA7);
        chk(got_first[0], "R4 first marker", got_first[0], 1);
        step(1'b1, 2'b00, 1'b0);
        chk(!byte_valid, "R4 single-cycle strobe", byte_valid, 0);
        for (int i = 0; i < 3; i++) sym(2'b00, 1'b0);
        send_byte(8'h3C, 1'b0);
        chk(nbytes == 3 && got_data[1] == 8'h00 && got_data[2] == 8'h3C,
            "R3 later bytes", got_data[2], 8'h3C);
        chk(!got_first[2], "R4 no first on later byte", got_first[2], 0);
        chk(nend == 0, "R7 no end while carrier", nend, 0);
        drop();
        chk(nend == 1, "R7 end beat after drop", nend, 1);
        chk(!end_err && !end_align, "R7 clean end", {end_err, end_align}, 0);
        drop();
        chk(nend == 1, "R7 end is one pulse", nend, 1);
    endtask

    task automatic t_ignore();
        clear();
        for (int i = 0; i < 8; i++) step(1'b0, i[1:0] | 2'b01, 1'b1);
        chk(nbytes == 0 && nend == 0, "R5 no output without carrier", nbytes + nend, 0);
        lead_in(0, 2);
        send_byte(8'h96, 1'b0);
        drop();
        chk(nbytes == 1 && got_data[0] == 8'h96, "R5 frame after noise", got_data[0], 8'h96);
        chk(!got_err[0] && !end_err, "R5 rx_er without carrier ignored", {got_err[0], end_err}, 0);
    endtask

    task automatic t_error();
        clear();
        lead_in(1, 2);
        send_byte(8'h11, 1'b0);
        send_byte(8'h22, 1'b1);
        send_byte(8'h33, 1'b0);
        drop();
        chk(nbytes == 3, "R6 byte count", nbytes, 3);
        chk(!got_err[0], "R6 byte before error clean", got_err[0], 0);
        chk(got_err[1] && got_err[2], "R6 error sticky", {got_err[1], got_err[2]}, 3);
        chk(nend == 1 && end_err, "R6 frame_err on end", end_err, 1);
    endtask

    task automatic t_align();
        clear();
        lead_in(0, 1);
        send_byte(8'hC3, 1'b0);
        sym(2'b10, 1'b0);
        sym(2'b11, 1'b0);
        drop();
        chk(nbytes == 1, "R8 partial byte dropped", nbytes, 1);
        chk(nend == 1 && end_align, "R8 alignment error", end_align, 1);
    endtask

    task automatic t_badpre();
        clear();
        sym(2'b11, 1'b0);
        send_byte(8'h5A, 1'b0);
        chk(nbytes == 0, "R11 11 without preamble", nbytes, 0);
        sym(2'b01, 1'b0);
        sym(2'b10, 1'b0);
        sym(2'b11, 1'b0);
        send_byte(8'hFF, 1'b0);
        send_byte(8'hFF, 1'b0);
        drop();
        chk(nbytes == 0 && nend == 0, "R11 broken preamble rehunts", nbytes + nend, 0);
    endtask

    task automatic t_slow();
        clear();
        speed_10 = 1'b1;
        lead_in(2, 2);
        send_byte(8'h5A, 1'b0);
        chk(nbytes == 1 && got_data[0] == 8'h5A, "R9 paced sampling", got_data[0], 8'h5A);
        send_byte(8'hE1, 1'b0);
        drop();
        chk(nbytes == 2 && got_data[1] == 8'hE1, "R9 second paced byte", got_data[1], 8'hE1);
        chk(nend == 1 && !end_align, "R9 end in slow mode", nend, 1);
        speed_10 = 1'b0;
    endtask

    task automatic t_col();
        clear();
        tx_en = 1'b1;
        step(1'b0, 2'b00, 1'b0);
        chk(!col, "R10 no col without carrier", col, 0);
        step(1'b1, 2'b00, 1'b0);
        chk(col, "R10 col one edge after overlap", col, 1);
        tx_en = 1'b0;
        step(1'b1, 2'b00, 1'b0);
        chk(!col, "R10 col clears with tx_en", col, 0);
        drop();
        chk(!col, "R10 col low after drop", col, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_ignore();
        t_error();
        t_align();
        t_badpre();
        t_slow();
        t_col();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule